// File: doc/BRIEF.md
# Self-Test Signature Controller

This block runs a built-in self-test over a processing datapath and condenses what the datapath produces into a 12-bit signature. The host first raises a test-mode control bit. The test itself begins on a channel-0 update strobe, but only while update-mask bit 15 is set.

Once started, the controller counts a programmable number of valid datapath samples. It folds each sample into a multiple-input signature register (MISR). When the last sample has been absorbed, the register freezes and a completion flag rises. The host reads the flag and the signature together from one 16-bit status word.

The datapath appears to the block as a generic data bus with a valid strobe. Loading configuration, coefficients and gain profiles before a test is the host's job and is not part of this block.

Top module: `bist_sig_ctrl`

## Requirements
- R1: While reset is active, and on the first cycle after reset, `status_o` reads 16'h0000.
- R2: The status word has the completion flag in bit 15, the signature in bits 14..3, and constant zero in bits 2..0.
- R3: A start occurs when `test_mode_i`, `upd_ch0_i` and `upd_mask15_i` are all high at a clock edge. After that edge the signature equals the seed 12'hA5C, the flag is 0, and `test_len_i` is taken as the sample count.
- R4: During a run, each cycle with `dp_valid_i` high advances the signature. With `s` the current signature and `f` the XOR of the 12-bit slices of `dp_data_i` (for the default 24-bit bus, `data[11:0] ^ data[23:12]`), the next signature is `{s[10:0],1'b0} ^ (s[11] ? 12'h053 : 12'h000) ^ f`. Cycles with `dp_valid_i` low leave the signature unchanged.
- R5: The flag is set on the edge after the sample count reaches zero. It rises only at the end of a run. From then on the signature holds, whatever `dp_valid_i` does, until the next start.
- R6: A start with `test_len_i` = 0 completes on the following edge with the seed as signature.
- R7: Any `upd_ch0_i` pulse clears the flag at that edge, whatever the values of `upd_mask15_i` and `test_mode_i`.
- R8: A rising edge of `test_mode_i` clears the flag. Lowering `test_mode_i` while idle leaves the flag unchanged.
- R9: A `upd_ch0_i` pulse with `test_mode_i` low, or with `upd_mask15_i` low, does not start a test: the signature is unchanged, and later valid samples do not advance it.
- R10: Lowering `test_mode_i` during a run aborts it. The signature freezes at its current value and the flag stays 0.
- R11: A start during a run restarts it from the seed, using the newly presented `test_len_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | Self-test arm bit from the top control register |
| upd_ch0_i | input | 1 | Channel-0 update strobe, one cycle |
| upd_mask15_i | input | 1 | Update-mask bit 15 |
| test_len_i | input | LEN_W (16) | Number of datapath samples in a test |
| dp_data_i | input | DATA_W (24) | Datapath output sample |
| dp_valid_i | input | 1 | Datapath sample valid |
| status_o | output | 16 | Flag in bit 15, signature in bits 14..3, zero in bits 2..0 |

## Verification
The bound checker watches, on every cycle:
- the zero low bits of the status word;
- the clearing of the flag by an update pulse and by a rising arm bit;
- that the signature does not move while disarmed or during a run's idle cycles;
- that the signature holds after completion;
- that the flag rises only out of a run;
- that a run ends when the arm bit drops.

Only the bench scenarios can show the exact signature values for several data patterns and gap patterns. The same holds for the sample count that ends a run, the zero-length test, the abort value and a restart in mid-run. The bench compares each of these against a model of the stated polynomial.

// File: rtl/bist_sig_pkg.sv
package bist_sig_pkg;

    localparam int unsigned SIG_W   = 12;
    localparam int unsigned STAT_W  = 16;
    localparam int unsigned SIG_LSB = 3;

    localparam logic [SIG_W-1:0] SIG_SEED = 12'hA5C;
    localparam logic [SIG_W-1:0] SIG_POLY = 12'h053;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/bist_fold.sv
// Compresses a wide sample into OUT_W bits by XOR of zero-padded slices.
module bist_fold #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned OUT_W  = 12
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [OUT_W-1:0]  fold_o
);
    localparam int unsigned SLICES = (DATA_W + OUT_W - 1) / OUT_W;
    localparam int unsigned PAD_W  = SLICES * OUT_W;

    logic [PAD_W-1:0] padded;
    logic [OUT_W-1:0] acc [0:SLICES];

    assign padded = PAD_W'(data_i);
    assign acc[0] = '0;

    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        assign acc[g+1] = acc[g] ^ padded[g*OUT_W +: OUT_W];
    end

    assign fold_o = acc[SLICES];
endmodule

// File: rtl/bist_misr_step.sv
// One combinational step of a shift-left MISR with feedback polynomial POLY.
module bist_misr_step #(
    parameter int unsigned          SIG_W = 12,
    parameter logic [SIG_W-1:0]     POLY  = 12'h053
) (
    input  logic [SIG_W-1:0] sig_i,
    input  logic [SIG_W-1:0] in_i,
    output logic [SIG_W-1:0] sig_o
);
    logic [SIG_W-1:0] feedback;

    assign feedback = sig_i[SIG_W-1] ? POLY : '0;
    assign sig_o    = {sig_i[SIG_W-2:0], 1'b0} ^ feedback ^ in_i;
endmodule

// File: rtl/bist_sig_ctrl.sv
module bist_sig_ctrl
    import bist_sig_pkg::*;
#(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              test_mode_i,
    input  logic              upd_ch0_i,
    input  logic              upd_mask15_i,
    input  logic [LEN_W-1:0]  test_len_i,
    input  logic [DATA_W-1:0] dp_data_i,
    input  logic              dp_valid_i,
    output logic [STAT_W-1:0] status_o
);
    typedef struct packed {
        phase_e            phase;
        logic              valid;
        logic              arm_prev;
        logic [SIG_W-1:0]  sig;
        logic [LEN_W-1:0]  cnt;
    } state_t;

    state_t state_d, state_q;

    logic             start;
    logic             arm_rise;
    logic             running;
    logic             cnt_zero;
    logic [SIG_W-1:0] folded;
    logic [SIG_W-1:0] sig_step;

    bist_fold #(
        .DATA_W (DATA_W),
        .OUT_W  (SIG_W)
    ) fold_i (
        .data_i (dp_data_i),
        .fold_o (folded)
    );

    bist_misr_step #(
        .SIG_W (SIG_W),
        .POLY  (SIG_POLY)
    ) misr_i (
        .sig_i (state_q.sig),
        .in_i  (folded),
        .sig_o (sig_step)
    );

    assign start    = test_mode_i & upd_ch0_i & upd_mask15_i;
    assign arm_rise = test_mode_i & ~state_q.arm_prev;
    assign running  = (state_q.phase == PH_RUN);
    assign cnt_zero = (state_q.cnt == '0);

    always_comb begin
        state_d          = state_q;
        state_d.arm_prev = test_mode_i;

        if (start) begin
            state_d.phase = PH_RUN;
            state_d.sig   = SIG_SEED;
            state_d.cnt   = test_len_i;
        end else if (!test_mode_i) begin
            state_d.phase = PH_IDLE;
        end else if (running) begin
            if (cnt_zero) begin
                state_d.phase = PH_IDLE;
                state_d.valid = 1'b1;
            end else if (dp_valid_i) begin
                state_d.sig = sig_step;
                state_d.cnt = state_q.cnt - LEN_W'(1);
            end
        end

        if (upd_ch0_i || arm_rise) begin
            state_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{phase: PH_IDLE, valid: 1'b0, arm_prev: 1'b0,
                         sig: '0, cnt: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = {state_q.valid, state_q.sig, {SIG_LSB{1'b0}}};

endmodule

// File: rtl/bist_sig_chk.sv
module bist_sig_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        test_mode_i,
    input logic        upd_ch0_i,
    input logic        dp_valid_i,
    input logic [15:0] status_o,
    input logic        run_i
);
    p_low_bits_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[2:0] == 3'b000);

    p_upd_clears_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_ch0_i |=> !status_o[15]);

    p_arm_clears_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(test_mode_i) |=> !status_o[15]);

    p_disarmed_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !test_mode_i |=> $stable(status_o[14:3]));

    p_hold_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[15] && !upd_ch0_i) |=> $stable(status_o[14:3]));

    p_valid_from_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[15]) |-> $past(run_i));

    p_abort_on_disarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !test_mode_i) |=> !run_i);

    p_gap_no_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !dp_valid_i && !upd_ch0_i) |=> $stable(status_o[14:3]));
endmodule

bind bist_sig_ctrl bist_sig_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .test_mode_i (test_mode_i),
    .upd_ch0_i   (upd_ch0_i),
    .dp_valid_i  (dp_valid_i),
    .status_o    (status_o),
    .run_i       (running)
);

// File: tb/bist_sig_ctrl_tb.sv
module bist_sig_ctrl_tb_top;
    localparam logic [11:0] SEED = 12'hA5C;

    // vector: {len[64:49], base[48:25], step[24:1], gap[0]}
    localparam int NVEC = 5;
    localparam logic [64:0] VEC [NVEC] = '{
        {16'd8,  24'h000001, 24'h000003, 1'b0},
        {16'd16, 24'h123456, 24'h010101, 1'b1},
        {16'd1,  24'hABCDEF, 24'h000000, 1'b0},
        {16'd33, 24'hFFFFFF, 24'h7FF801, 1'b1},
        {16'd3,  24'h800800, 24'h000800, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_mode = 1'b0;
    logic        upd_ch0 = 1'b0;
    logic        mask15 = 1'b0;
    logic [15:0] test_len = '0;
    logic [23:0] dp_data = '0;
    logic        dp_valid = 1'b0;
    logic [15:0] status;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bist_sig_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode),
        .upd_ch0_i(upd_ch0), .upd_mask15_i(mask15), .test_len_i(test_len),
        .dp_data_i(dp_data), .dp_valid_i(dp_valid), .status_o(status)
    );

    function automatic logic [11:0] mstep(logic [11:0] s, logic [23:0] d);
        return {s[10:0], 1'b0} ^ (s[11] ? 12'h053 : 12'h000) ^ d[11:0] ^ d[23:12];
    endfunction

    function automatic logic [11:0] model(int n, logic [23:0] base, logic [23:0] step);
        logic [11:0] s = SEED;
        for (int i = 0; i < n; i++) s = mstep(s, base + 24'(i) * step);
        return s;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_upd(logic m);
        upd_ch0 = 1'b1; mask15 = m;
        tick();
        upd_ch0 = 1'b0; mask15 = 1'b0;
    endtask

    task automatic feed(int n, logic [23:0] base, logic [23:0] step, logic gap);
        for (int i = 0; i < n; i++) begin
            dp_data = base + 24'(i) * step; dp_valid = 1'b1;
            tick();
            dp_valid = 1'b0;
            if (gap) begin
                dp_data = 24'hFFFFFF;
                tick();
            end
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [11:0] s;
        tick();
        check("R1 in reset", status, 16'h0000);
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 after reset", status, 16'h0000);
        test_mode = 1'b1;
        tick();

        // table walk: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            test_len = VEC[v][64:49];
            pulse_upd(1'b1);
            check("R3 seed loaded", status, {1'b0, SEED, 3'b000});
            feed(int'(VEC[v][64:49]), VEC[v][48:25], VEC[v][24:1], VEC[v][0]);
            tick(); tick();
            s = model(int'(VEC[v][64:49]), VEC[v][48:25], VEC[v][24:1]);
            check("R4 R2 signature", status, {1'b1, s, 3'b000});
        end

        // R5 hold after completion
        feed(4, 24'h0F0F0F, 24'h111111, 1'b0);
        check("R5 hold", status, {1'b1, s, 3'b000});

        // R9/R7: update without mask
        pulse_upd(1'b0);
        check("R7 clear no mask", status, {1'b0, s, 3'b000});
        feed(3, 24'h333333, 24'h1, 1'b0);
        tick();
        check("R9 mask low ignored", status, {1'b0, s, 3'b000});

        // R6 zero length
        test_len = 16'd0;
        pulse_upd(1'b1);
        tick();
        check("R6 zero length", status, {1'b1, SEED, 3'b000});

        // R8: drop while idle keeps flag, rise clears
        test_mode = 1'b0;
        tick();
        check("R8 drop keeps flag", status, {1'b1, SEED, 3'b000});
        test_mode = 1'b1;
        tick();
        check("R8 rise clears", status, {1'b0, SEED, 3'b000});

        // R9: disarmed start ignored
        test_len = 16'd4;
        pulse_upd(1'b1);
        feed(4, 24'h010203, 24'h000100, 1'b0);
        tick(); tick();
        s = model(4, 24'h010203, 24'h000100);
        check("R9 setup run", status, {1'b1, s, 3'b000});
        test_mode = 1'b0;
        tick();
        pulse_upd(1'b1);
        check("R7 clear disarmed", status, {1'b0, s, 3'b000});
        feed(3, 24'h555555, 24'h2, 1'b0);
        check("R9 disarmed ignored", status, {1'b0, s, 3'b000});
        test_mode = 1'b1;
        tick();

        // R10 abort
        test_len = 16'd10;
        pulse_upd(1'b1);
        feed(2, 24'h00ABC0, 24'h000777, 1'b0);
        test_mode = 1'b0;
        tick();
        feed(3, 24'h999999, 24'h1, 1'b0);
        tick(); tick();
        s = model(2, 24'h00ABC0, 24'h000777);
        check("R10 abort frozen", status, {1'b0, s, 3'b000});
        test_mode = 1'b1;
        tick();

        // R11 restart mid-run
        test_len = 16'd10;
        pulse_upd(1'b1);
        feed(3, 24'h444444, 24'h3, 1'b0);
        test_len = 16'd5;
        pulse_upd(1'b1);
        check("R11 reseeded", status, {1'b0, SEED, 3'b000});
        feed(5, 24'h0A0B0C, 24'h102030, 1'b1);
        tick(); tick();
        s = model(5, 24'h0A0B0C, 24'h102030);
        check("R11 restart result", status, {1'b1, s, 3'b000});

        done = 1'b1;
        report();
    end
endmodule